// File: doc/BRIEF.md
# SWD Access-Port Read Sequencer

This block sits above a Serial Wire Debug transfer engine and turns one command into the full series of wire transfers needed to fetch an access-port register. For an access-port command it first programs the debug port's bank selector (SELECT). It then reads the access-port register twice, because access-port read data is posted: the value returned by a read belongs to the previous access-port read. It returns the second value. A debug-port command is forwarded as a single read.

Commands arrive on a valid/ready handshake with a flag that picks access port or debug port, and a 32-bit address. For an access port, address bits [31:24] carry the port number, bits [7:4] carry the register bank and bits [3:2] pick the register within the bank. A debug-port command uses only bits [3:2]. Each command produces a one-cycle result strobe with 32-bit data and an error flag. The engine side uses a request valid/ready pair followed by a one-cycle response strobe that carries the 3-bit acknowledge and the read data.

Top module: `swd_ap_read_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `res_valid` is 0 and `eng_req_valid` is 0.
- R2: The first engine request of an access-port command is a debug-port write (`eng_req_apndp`=0, `eng_req_rnw`=0) with `eng_req_a`=2'b10, which is offset 0x8, the selector register. Its write data is the command address ANDed with 32'hFF00_00F0.
- R3: The OK acknowledge is encoded as 3'b001. If the selector write returns any other acknowledge, no access-port read is issued. The result then has `res_err`=1 and `res_data`=0, and the command has used exactly one transfer.
- R4: After a successful selector write, exactly two access-port reads follow (`eng_req_apndp`=1, `eng_req_rnw`=1, `eng_req_a` = address bits [3:2]). The result data is the second read's data.
- R5: The acknowledge of the first, discarded access-port read does not affect the result.
- R6: If the final read's acknowledge is not 3'b001, the result has `res_err`=1 and `res_data`=0. Otherwise `res_err` is 0.
- R7: A debug-port command is one read transfer (`eng_req_apndp`=0, `eng_req_rnw`=1, `eng_req_a` = address bits [3:2]) with no selector write. Its data is returned as the result.
- R8: `res_valid` is high for exactly one cycle per command. `cmd_ready` is low from the cycle after acceptance through the result cycle, and high again in the following cycle.
- R9: Once `eng_req_valid` is raised, it and all request fields stay stable until a cycle with `eng_req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command accepted when both high |
| cmd_is_ap | input | 1 | 1 = access-port read, 0 = debug-port read |
| cmd_addr | input | 32 | Port number [31:24], bank [7:4], register [3:2] |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 32 | Read data, 0 on error |
| res_err | output | 1 | Final or selector acknowledge not OK |
| eng_req_valid | output | 1 | Transfer request to engine |
| eng_req_ready | input | 1 | Engine takes the request |
| eng_req_apndp | output | 1 | 1 = access port, 0 = debug port |
| eng_req_rnw | output | 1 | 1 = read, 0 = write |
| eng_req_a | output | 2 | Register address bits [3:2] |
| eng_req_wdata | output | 32 | Write data (selector word) |
| eng_rsp_valid | input | 1 | One-cycle transfer response strobe |
| eng_rsp_ack | input | 3 | Acknowledge, 3'b001 = OK |
| eng_rsp_rdata | input | 32 | Transfer read data |

## Verification
The assertions assume that the engine raises `eng_rsp_valid` once per accepted request, and only after that request has been taken. They also assume that `cmd_valid` is raised only while the testbench waits for `cmd_ready`. The bench's engine model answers each request once, after a chosen number of idle cycles, and each command is driven only after the previous result has been seen. The model returns posted access-port data, so a sequencer that returned the first read would produce the previous register's value.

// File: rtl/swd_apseq_pkg.sv
// Package: shared state encoding and protocol constants of the AP read
// sequencer. Assumes the standard 3-bit SWD acknowledge encoding.
package swd_apseq_pkg;

    localparam int ACK_W = 3;
    localparam logic [ACK_W-1:0] ACK_OK = 3'b001;
    localparam logic [1:0] DP_SELECT_A = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_REQ,
        ST_SEL_WAIT,
        ST_RD1_REQ,
        ST_RD1_WAIT,
        ST_FIN_REQ,
        ST_FIN_WAIT,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/swd_apseq_decode.sv
// Module: address decoder. Builds the selector word by keeping only the
// port-number and bank fields of a latched address, and extracts the
// register field. Purely combinational; assumes fields do not overlap A[3:2].
module swd_apseq_decode #(
    parameter int ADDR_W    = 32,
    parameter int APSEL_LSB = 24,
    parameter int APSEL_W   = 8,
    parameter int BANK_LSB  = 4,
    parameter int BANK_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] sel_mask,
    output logic [ADDR_W-1:0] sel_word,
    output logic [1:0]        reg_a
);

    localparam int APSEL_TOP = APSEL_LSB + APSEL_W;
    localparam int BANK_TOP  = BANK_LSB + BANK_W;

    // Mask bit per address bit: set inside either field.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign sel_mask[i] = ((i >= APSEL_LSB) && (i < APSEL_TOP)) ||
                             ((i >= BANK_LSB) && (i < BANK_TOP));
    end

    // Selector word and register field from the address.
    always_comb begin
        sel_word = addr & sel_mask;
        reg_a    = addr[3:2];
    end

endmodule

// File: rtl/swd_apseq_result.sv
// Module: result register. Captures data and error flag on the final
// transfer response or on a failed selector write. Assumes the two
// capture strobes are never high together.
module swd_apseq_result
    import swd_apseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_final,
    input  logic              cap_selfail,
    input  logic [ACK_W-1:0]  ack,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err
);

    // Hold the outcome of the command until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
            res_err  <= 1'b0;
        end else if (cap_final) begin
            res_err  <= (ack != ACK_OK);
            res_data <= (ack == ACK_OK) ? rdata : '0;
        end else if (cap_selfail) begin
            res_err  <= 1'b1;
            res_data <= '0;
        end
    end

endmodule

// File: rtl/swd_apseq_fsm.sv
// Module: sequencing state machine. Accepts a command, issues the selector
// write and two AP reads (or one DP read) to the engine, and strobes the
// result for one cycle. Assumes the engine answers each taken request once.
module swd_apseq_fsm
    import swd_apseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_ap,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic [ADDR_W-1:0] addr_q,
    input  logic [ADDR_W-1:0] sel_word,
    input  logic [1:0]        reg_a,
    output logic              eng_req_valid,
    input  logic              eng_req_ready,
    output logic              eng_req_apndp,
    output logic              eng_req_rnw,
    output logic [1:0]        eng_req_a,
    output logic [ADDR_W-1:0] eng_req_wdata,
    input  logic              eng_rsp_valid,
    input  logic [ACK_W-1:0]  eng_rsp_ack,
    output logic              cap_final,
    output logic              cap_selfail,
    output logic              res_valid
);

    seq_state_t state_q, state_d;
    logic       is_ap_q;

    // State register and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            is_ap_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd_valid && cmd_ready) begin
                addr_q  <= cmd_addr;
                is_ap_q <= cmd_is_ap;
            end
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid) state_d = cmd_is_ap ? ST_SEL_REQ : ST_FIN_REQ;
            ST_SEL_REQ:  if (eng_req_ready) state_d = ST_SEL_WAIT;
            ST_SEL_WAIT: if (eng_rsp_valid)
                             state_d = (eng_rsp_ack == ACK_OK) ? ST_RD1_REQ : ST_DONE;
            ST_RD1_REQ:  if (eng_req_ready) state_d = ST_RD1_WAIT;
            ST_RD1_WAIT: if (eng_rsp_valid) state_d = ST_FIN_REQ;
            ST_FIN_REQ:  if (eng_req_ready) state_d = ST_FIN_WAIT;
            ST_FIN_WAIT: if (eng_rsp_valid) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Engine request fields and handshake outputs decoded from state.
    always_comb begin
        cmd_ready     = (state_q == ST_IDLE);
        res_valid     = (state_q == ST_DONE);
        eng_req_valid = (state_q == ST_SEL_REQ) || (state_q == ST_RD1_REQ) ||
                        (state_q == ST_FIN_REQ);
        eng_req_apndp = (state_q == ST_RD1_REQ) || ((state_q == ST_FIN_REQ) && is_ap_q);
        eng_req_rnw   = (state_q != ST_SEL_REQ);
        eng_req_a     = (state_q == ST_SEL_REQ) ? DP_SELECT_A : reg_a;
        eng_req_wdata = (state_q == ST_SEL_REQ) ? sel_word : '0;
        cap_final     = (state_q == ST_FIN_WAIT) && eng_rsp_valid;
        cap_selfail   = (state_q == ST_SEL_WAIT) && eng_rsp_valid && (eng_rsp_ack != ACK_OK);
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid && !eng_req_ready |=> eng_req_valid && $stable(eng_req_a) &&
        $stable(eng_req_apndp) && $stable(eng_req_rnw) && $stable(eng_req_wdata));

    assert_res_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && cmd_ready);

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cmd_ready);

    assert_selfail_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEL_WAIT) && eng_rsp_valid && (eng_rsp_ack != ACK_OK)
        |=> res_valid && !eng_req_valid);

endmodule

// File: rtl/swd_ap_read_seq.sv
// Module: top of the AP read sequencer. Wires the decoder, state machine
// and result register. Assumes a single outstanding engine transfer.
module swd_ap_read_seq
    import swd_apseq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int APSEL_LSB = 24,
    parameter int APSEL_W   = 8,
    parameter int BANK_LSB  = 4,
    parameter int BANK_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_is_ap,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err,
    output logic              eng_req_valid,
    input  logic              eng_req_ready,
    output logic              eng_req_apndp,
    output logic              eng_req_rnw,
    output logic [1:0]        eng_req_a,
    output logic [ADDR_W-1:0] eng_req_wdata,
    input  logic              eng_rsp_valid,
    input  logic [2:0]        eng_rsp_ack,
    input  logic [DATA_W-1:0] eng_rsp_rdata
);

    logic [ADDR_W-1:0] addr_q, sel_mask, sel_word;
    logic [1:0]        reg_a;
    logic              cap_final, cap_selfail;

    swd_apseq_decode #(
        .ADDR_W(ADDR_W), .APSEL_LSB(APSEL_LSB), .APSEL_W(APSEL_W),
        .BANK_LSB(BANK_LSB), .BANK_W(BANK_W)
    ) u_decode (
        .addr(addr_q), .sel_mask(sel_mask), .sel_word(sel_word), .reg_a(reg_a)
    );

    swd_apseq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_is_ap(cmd_is_ap), .cmd_addr(cmd_addr),
        .cmd_ready(cmd_ready), .addr_q(addr_q),
        .sel_word(sel_word), .reg_a(reg_a),
        .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_req_apndp(eng_req_apndp), .eng_req_rnw(eng_req_rnw),
        .eng_req_a(eng_req_a), .eng_req_wdata(eng_req_wdata),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ack(eng_rsp_ack),
        .cap_final(cap_final), .cap_selfail(cap_selfail), .res_valid(res_valid)
    );

    swd_apseq_result #(.DATA_W(DATA_W)) u_result (
        .clk(clk), .rst_n(rst_n),
        .cap_final(cap_final), .cap_selfail(cap_selfail),
        .ack(eng_rsp_ack), .rdata(eng_rsp_rdata),
        .res_data(res_data), .res_err(res_err)
    );

    assert_sel_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid && !eng_req_rnw |-> !eng_req_apndp &&
        (eng_req_a == DP_SELECT_A) && ((eng_req_wdata & ~sel_mask) == '0));

    assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_err |-> (res_data == '0));

endmodule

// File: tb/tb_swd_ap_read_seq.sv
module tb_swd_ap_read_seq;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'hFF00_00F0;
    localparam logic [2:0] OK = 3'b001, WT = 3'b010, FT = 3'b100;
    localparam int NVEC = 12;

    // {is_ap, addr, ack_sel_or_dp, ack_rd1, ack_final, ready_delay, rsp_delay}
    localparam logic [45:0] VEC [NVEC] = '{
        {1'b1, 32'h0100_0000, OK, OK, OK, 2'd0, 2'd0},
        {1'b1, 32'h0200_0004, OK, OK, OK, 2'd1, 2'd2},
        {1'b1, 32'h0300_00FC, OK, OK, OK, 2'd2, 2'd1},
        {1'b0, 32'h0000_0000, OK, OK, OK, 2'd0, 2'd0},
        {1'b0, 32'h0000_0004, OK, OK, OK, 2'd1, 2'd1},
        {1'b1, 32'h0400_001C, WT, OK, OK, 2'd3, 2'd0},
        {1'b1, 32'h0500_002C, FT, OK, OK, 2'd0, 2'd1},
        {1'b1, 32'h0600_000C, OK, FT, OK, 2'd1, 2'd0},
        {1'b1, 32'h0700_0008, OK, OK, WT, 2'd0, 2'd2},
        {1'b0, 32'h0000_000C, FT, OK, OK, 2'd2, 2'd0},
        {1'b1, 32'hFF00_00F4, OK, OK, OK, 2'd3, 2'd3},
        {1'b0, 32'h0000_0008, OK, OK, OK, 2'd0, 2'd3}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_is_ap = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic        cmd_ready, res_valid, res_err;
    logic [31:0] res_data;
    logic        eng_req_valid, eng_req_apndp, eng_req_rnw;
    logic [1:0]  eng_req_a;
    logic [31:0] eng_req_wdata;
    logic        eng_req_ready = 1'b0, eng_rsp_valid = 1'b0;
    logic [2:0]  eng_rsp_ack = '0;
    logic [31:0] eng_rsp_rdata = '0;

    int checks = 0, errors = 0, cyc = 0;
    int xf_cnt = 0, bad_cnt = 0, rdy_dly = 0, rsp_dly = 0;
    logic [2:0]  ack_script [3];
    logic [31:0] eng_sel = '0, ap_prev = 32'hDEAD_BEEF, exp_addr = '0;
    bit          exp_is_ap = 1'b0;

    swd_ap_read_seq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ap_val(input logic [31:0] sel, input logic [1:0] a);
        return (sel ^ 32'h3C3C_0000) + {28'h0, a, 2'b00} + 32'h0000_1100;
    endfunction

    function automatic logic [31:0] dp_val(input logic [1:0] a);
        return 32'hD0D0_0000 | {30'h0, a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Engine model: takes requests after a delay, answers with posted AP data.
    initial begin
        ack_script[0] = OK; ack_script[1] = OK; ack_script[2] = OK;
        forever begin
            @(negedge clk);
            if (rst_n && eng_req_valid) begin
                logic       ap, rnw;
                logic [1:0] a;
                logic [31:0] wd, rd;
                logic [2:0] ack;
                int         idx;
                repeat (rdy_dly) @(negedge clk);
                ap = eng_req_apndp; rnw = eng_req_rnw; a = eng_req_a; wd = eng_req_wdata;
                eng_req_ready = 1'b1;
                @(negedge clk);
                eng_req_ready = 1'b0;
                idx = xf_cnt;
                ack = ack_script[(idx < 3) ? idx : 2];
                if (exp_is_ap) begin
                    if (idx == 0) begin
                        if (ap || rnw || a != 2'b10 || wd != (exp_addr & MASK)) bad_cnt++;
                    end else if (idx <= 2) begin
                        if (!ap || !rnw || a != exp_addr[3:2]) bad_cnt++;
                    end else bad_cnt++;
                end else begin
                    if (idx != 0 || ap || !rnw || a != exp_addr[3:2]) bad_cnt++;
                end
                if (!ap && !rnw) begin
                    if (ack == OK) eng_sel = wd;
                    rd = 32'h0;
                end else if (ap) begin
                    rd = ap_prev;
                    ap_prev = ap_val(eng_sel, a);
                end else rd = dp_val(a);
                xf_cnt++;
                repeat (rsp_dly) @(negedge clk);
                eng_rsp_valid = 1'b1; eng_rsp_ack = ack; eng_rsp_rdata = rd;
                @(negedge clk);
                eng_rsp_valid = 1'b0;
            end
        end
    end

    task automatic run_cmd(input logic [45:0] v);
        logic        is_ap;
        logic [31:0] addr, exp_data;
        logic [2:0]  a0, a1, a2;
        bit          exp_err;
        int          exp_xf, n, bad0;
        {is_ap, addr, a0, a1, a2} = v[45:4];
        rdy_dly = int'(v[3:2]); rsp_dly = int'(v[1:0]);
        ack_script[0] = a0; ack_script[1] = a1; ack_script[2] = a2;
        exp_addr = addr; exp_is_ap = is_ap; xf_cnt = 0; bad0 = bad_cnt;
        if (!is_ap) begin
            exp_err = (a0 != OK); exp_xf = 1;
            exp_data = exp_err ? 32'h0 : dp_val(addr[3:2]);
        end else if (a0 != OK) begin
            exp_err = 1'b1; exp_xf = 1; exp_data = 32'h0;
        end else begin
            exp_err = (a2 != OK); exp_xf = 3;
            exp_data = exp_err ? 32'h0 : ap_val(addr & MASK, addr[3:2]);
        end
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R8", "ready before command", {31'h0, cmd_ready}, 32'h1);
        cmd_valid = 1'b1; cmd_is_ap = is_ap; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R8", "ready while busy", {31'h0, cmd_ready}, 32'h0);
        n = 0;
        while (!res_valid && n < 300) begin @(negedge clk); n++; end
        chk(res_err == exp_err, is_ap ? "R3_R6" : "R7", "error flag", {31'h0, res_err}, {31'h0, exp_err});
        chk(res_data == exp_data, is_ap ? "R4_R5" : "R7", "result data", res_data, exp_data);
        chk(cmd_ready == 1'b0, "R8", "ready during result", {31'h0, cmd_ready}, 32'h0);
        @(negedge clk);
        chk(res_valid == 1'b0 && cmd_ready == 1'b1, "R8", "result one cycle",
            {30'h0, res_valid, cmd_ready}, 32'h1);
        chk(xf_cnt == exp_xf, is_ap ? "R3_R4" : "R7", "transfer count", xf_cnt, exp_xf);
        chk(bad_cnt == bad0, is_ap ? "R2_R4_R9" : "R7", "request fields", bad_cnt - bad0, 0);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cmd_ready && !res_valid && !eng_req_valid, "R1", "reset outputs",
            {29'h0, cmd_ready, res_valid, eng_req_valid}, 32'h4);
        for (int i = 0; i < NVEC; i++) run_cmd(VEC[i]);
        // Corner: same port and bank, different register back to back (R4 posted data)
        run_cmd({1'b1, 32'h0200_0000, OK, OK, OK, 2'd0, 2'd0});
        run_cmd({1'b1, 32'h0200_000C, OK, OK, OK, 2'd0, 2'd0});
        // Corner: reset while idle returns to reset state (R1)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !res_valid && !eng_req_valid, "R1", "reset outputs again",
            {29'h0, cmd_ready, res_valid, eng_req_valid}, 32'h4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule